// File: doc/BRIEF.md
# GPIO Event Detector and Interrupt Combiner

This block holds the per-pin event logic that sits behind a bank of general purpose input pins. It receives the input-data word after polarity correction, together with a mask that marks which bits of that word changed in the current cycle. For every pin it decides, from that pin's trigger-type and both-edge settings, whether an event occurred. If one did, it sets a sticky status bit. The status bits that are also enabled are combined into one registered interrupt line.

Software configures the block through a simple single-cycle write port. The trigger type, the both-edge selection and the enable word can each be written whole. The enable word can also be changed bit by bit through a set alias and a clear alias. Status bits are cleared by writing ones. Level-triggered pins are evaluated again on every cycle. A pin that is still high after its status was cleared therefore sets its status again straight away.

Top module: `gpio_event_irq`

## Requirements
- R1: While reset is asserted and immediately after it, status is all zeros, irq is 0 and enable equals the RESET_ENABLE parameter (default 0). Trigger type and both-edge selection also reset to 0.
- R2: A pin whose trigger-type bit is 0 is level-triggered. On every clock edge where its in_data bit is 1, its status bit is 1 after that edge.
- R3: A pin whose trigger-type bit is 1 sets its status bit on an edge where in_chg and in_data are both 1 for that pin (a rising change). It does this whatever the both-edge bit is. A falling change (in_chg 1, in_data 0) does not set status when the both-edge bit is 0.
- R4: A pin whose trigger-type bit and both-edge bit are both 1 sets its status bit on any edge where its in_chg bit is 1, including falling changes.
- R5: A status bit that is set stays set on later cycles when its condition has gone away, until it is cleared by a write.
- R6: A write with wr_addr 5 clears each status bit whose wr_data bit is 1. Status bits whose wr_data bit is 0 are unchanged.
- R7: If a set condition and a clear write hit the same status bit in the same cycle, the bit ends up set. A level pin that is still high therefore re-arms at once.
- R8: A write with wr_addr 2 loads enable with wr_data. wr_addr 3 sets the enable bits marked by ones in wr_data. wr_addr 4 clears the enable bits marked by ones in wr_data.
- R9: irq is registered. After each edge it equals the OR of (status AND enable) as those registers held before that edge, which is one cycle after a status or enable change.
- R10: A write with wr_addr 0 loads the trigger-type word and wr_addr 1 loads the both-edge word. The new values govern event detection from the following edge on.
- R11: A write with wr_addr 6 or 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | NUM_PINS | Polarity-corrected input-data word |
| in_chg | input | NUM_PINS | Bits of in_data that changed this cycle |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write target: 0 type, 1 both-edge, 2 enable, 3 enable set, 4 enable clear, 5 status clear |
| wr_data | input | NUM_PINS | Write data or bit mask |
| status | output | NUM_PINS | Sticky event-status bits |
| enable | output | NUM_PINS | Event-enable bits |
| irq | output | 1 | Registered interrupt request |

## Verification
Status and enable respond on the first clock edge after the cycle in which the stimulus or write is presented. irq follows the status and enable registers one edge later. The driver presents one stimulus per cycle. For each stimulus it computes, from the requirements, the status, enable and irq values expected after the next edge and queues them. The monitor takes one item from the queue shortly after every rising edge and compares, so every expectation is checked at the edge it belongs to. For irq this is the edge after the one that moved the status or enable bit it depends on.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      WSEL_TYPE    = 3'd0,
      WSEL_BOTH    = 3'd1,
      WSEL_ENA     = 3'd2,
      WSEL_ENA_SET = 3'd3,
      WSEL_ENA_CLR = 3'd4,
      WSEL_ST_CLR  = 3'd5
   } wsel_e;

endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NUM_PINS     = 32,
   parameter logic [NUM_PINS-1:0] RESET_ENABLE = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [NUM_PINS-1:0] wr_data,
   output logic [NUM_PINS-1:0] trig_type,
   output logic [NUM_PINS-1:0] trig_both,
   output logic [NUM_PINS-1:0] ena
);

   logic [NUM_PINS-1:0] type_q, both_q, ena_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         type_q <= '0;
         both_q <= '0;
         ena_q  <= RESET_ENABLE;
      end else if (wr_en) begin
         case (wr_addr)
            WSEL_TYPE:    type_q <= wr_data;
            WSEL_BOTH:    both_q <= wr_data;
            WSEL_ENA:     ena_q  <= wr_data;
            WSEL_ENA_SET: ena_q  <= ena_q | wr_data;
            WSEL_ENA_CLR: ena_q  <= ena_q & ~wr_data;
            default: ;
         endcase
      end
   end

   assign trig_type = type_q;
   assign trig_both = both_q;
   assign ena       = ena_q;

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] in_data,
   input  logic [NUM_PINS-1:0] in_chg,
   input  logic [NUM_PINS-1:0] trig_type,
   input  logic [NUM_PINS-1:0] trig_both,
   input  logic [NUM_PINS-1:0] clr_mask,
   output logic [NUM_PINS-1:0] st
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic hit;
      logic st_q;

      always_comb begin
         if (!trig_type[p])
            hit = in_data[p];
         else
            hit = in_chg[p] & (in_data[p] | trig_both[p]);
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            st_q <= 1'b0;
         else if (hit)
            st_q <= 1'b1;
         else if (clr_mask[p])
            st_q <= 1'b0;
      end

      assign st[p] = st_q;
   end

endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] st,
   input  logic [NUM_PINS-1:0] ena,
   output logic                irq
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(st & ena);
   end

   assign irq = irq_q;

endmodule

// File: rtl/gpio_event_irq.sv
module gpio_event_irq
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NUM_PINS     = 32,
   parameter logic [NUM_PINS-1:0] RESET_ENABLE = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] in_data,
   input  logic [NUM_PINS-1:0] in_chg,
   input  logic                wr_en,
   input  logic [2:0]          wr_addr,
   input  logic [NUM_PINS-1:0] wr_data,
   output logic [NUM_PINS-1:0] status,
   output logic [NUM_PINS-1:0] enable,
   output logic                irq
);

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_width
      $error("gpio_event_irq: NUM_PINS must be 1..32");
   end

   logic [NUM_PINS-1:0] type_w, both_w, ena_w, st_w, clr_w;

   assign clr_w = (wr_en && wr_addr == WSEL_ST_CLR) ? wr_data : '0;

   gpio_evt_cfg #(.NUM_PINS(NUM_PINS), .RESET_ENABLE(RESET_ENABLE)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .trig_type(type_w), .trig_both(both_w), .ena(ena_w)
   );

   gpio_evt_status #(.NUM_PINS(NUM_PINS)) u_status (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_chg(in_chg),
      .trig_type(type_w), .trig_both(both_w), .clr_mask(clr_w), .st(st_w)
   );

   gpio_evt_irq #(.NUM_PINS(NUM_PINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .st(st_w), .ena(ena_w), .irq(irq)
   );

   assign status = st_w;
   assign enable = ena_w;

endmodule

// File: rtl/gpio_event_irq_chk.sv
module gpio_event_irq_chk #(
   parameter int unsigned NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] in_data,
   input logic [NUM_PINS-1:0] in_chg,
   input logic                wr_en,
   input logic [2:0]          wr_addr,
   input logic [NUM_PINS-1:0] wr_data,
   input logic [NUM_PINS-1:0] evt_type,
   input logic [NUM_PINS-1:0] evt_both,
   input logic [NUM_PINS-1:0] status,
   input logic [NUM_PINS-1:0] enable,
   input logic                irq
);

   // R2
   level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(~evt_type & in_data) & ~status) == '0));

   // R4
   edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt_type & in_chg & (in_data | evt_both)) & ~status) == '0));

   // R5
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == 3'd5) |=> ((status & $past(status)) == $past(status)));

   // R8
   ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd3) |=> ((enable & $past(wr_data)) == $past(wr_data)));

   // R8
   ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd4) |=> ((enable & $past(wr_data)) == '0));

   // R9
   irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == |($past(status & enable))));

endmodule

bind gpio_event_irq gpio_event_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_chg(in_chg),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .evt_type(type_w), .evt_both(both_w),
   .status(status), .enable(enable), .irq(irq)
);

// File: tb/tb_gpio_event_irq.sv
`timescale 1ns/1ps
module tb_gpio_event_irq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_data = '0, in_chg = '0, wr_data = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] status, enable;
   logic        irq;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [31:0] st;
      logic [31:0] en;
      logic        irq;
      string       tag;
   } exp_t;

   exp_t sb[$];

   logic [31:0] m_type = '0, m_both = '0, m_en = '0, m_st = '0;

   always #4 clk = ~clk;

   gpio_event_irq dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_chg(in_chg),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .status(status), .enable(enable), .irq(irq)
   );

   task automatic step(input logic [31:0] d, input logic [31:0] c,
                       input logic we, input logic [2:0] a,
                       input logic [31:0] wd, input string tag);
      logic [31:0] set_v, clr_v;
      exp_t e;
      @(negedge clk);
      in_data = d; in_chg = c; wr_en = we; wr_addr = a; wr_data = wd;
      set_v = (~m_type & d) | (m_type & c & (d | m_both));
      clr_v = (we && a == 3'd5) ? wd : '0;
      e.irq = |(m_st & m_en);
      m_st  = (m_st & ~clr_v) | set_v;
      if (we) begin
         case (a)
            3'd0: m_type = wd;
            3'd1: m_both = wd;
            3'd2: m_en   = wd;
            3'd3: m_en   = m_en | wd;
            3'd4: m_en   = m_en & ~wd;
            default: ;
         endcase
      end
      e.st = m_st; e.en = m_en; e.tag = tag;
      sb.push_back(e);
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (status !== e.st || enable !== e.en || irq !== e.irq) begin
            errors++;
            $display("FAIL %s: status=%h enable=%h irq=%b expected status=%h enable=%h irq=%b",
                     e.tag, status, enable, irq, e.st, e.en, e.irq);
         end
      end
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (status !== '0 || enable !== '0 || irq !== 1'b0) begin
         errors++;
         $display("FAIL R1: status=%h enable=%h irq=%b expected 0 0 0", status, enable, irq);
      end
      @(negedge clk);
      rst_n = 1'b1;
      // R1 values just after release
      step('0, '0, 0, 3'd0, '0, "R1");
      // R2 level pins
      step(32'h5, 32'h5, 0, 3'd0, '0, "R2");
      // R5 sticky after input falls
      step(32'h0, 32'h5, 0, 3'd0, '0, "R5");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R5");
      // R8 direct enable write, R9 irq one cycle later
      step(32'h0, 32'h0, 1, 3'd2, 32'h1, "R8");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R9");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R9");
      // R6 partial clear
      step(32'h0, 32'h0, 1, 3'd5, 32'h4, "R6");
      step(32'h0, 32'h0, 1, 3'd5, 32'h1, "R6");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R9");
      // R7 set wins over clear, level re-arm
      step(32'h1, 32'h1, 0, 3'd0, '0, "R7");
      step(32'h1, 32'h0, 1, 3'd5, 32'h1, "R7");
      step(32'h0, 32'h1, 0, 3'd0, '0, "R7");
      step(32'h0, 32'h0, 1, 3'd5, 32'h1, "R6");
      // R10 type write, R3 rising edges only
      step(32'h0, 32'h0, 1, 3'd0, 32'hFFFF_0000, "R10");
      step(32'h0001_0000, 32'h0001_0000, 0, 3'd0, '0, "R3");
      step(32'h0, 32'h0001_0000, 1, 3'd5, 32'h0001_0000, "R3");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R3");
      step(32'h0002_0000, 32'h0, 0, 3'd0, '0, "R3");
      // R4 both-edge mode catches falling
      step(32'h0002_0000, 32'h0, 1, 3'd1, 32'h0002_0000, "R10");
      step(32'h0, 32'h0002_0000, 0, 3'd0, '0, "R4");
      step(32'h0002_0000, 32'h0002_0000, 0, 3'd0, '0, "R4");
      // R8 alias set and clear
      step(32'h0, 32'h0, 1, 3'd3, 32'h0003_00F0, "R8");
      step(32'h0, 32'h0, 1, 3'd4, 32'h0001_0010, "R8");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R9");
      // R11 unused addresses
      step(32'h0, 32'h0, 1, 3'd6, 32'hFFFF_FFFF, "R11");
      step(32'h0, 32'h0, 1, 3'd7, 32'hFFFF_FFFF, "R11");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R11");
      // R9 irq falls after clearing all status
      step(32'h0, 32'h0, 1, 3'd5, 32'hFFFF_FFFF, "R9");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R9");
      step(32'h0, 32'h0, 0, 3'd0, '0, "R9");
      while (sb.size() > 0) @(posedge clk);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule